// File: doc/BRIEF.md
# Timer Snapshot Read Latch

This block is the host read path for a bank of 16-bit down-counters. Each counter appears to the host as two 8-bit registers at consecutive byte addresses. A plain read of those addresses returns the preset value that the counter reloads from. It does not return the running count.

To see the live count, the host sets a per-timer read request. The request is registered first and arms the channel. The channel then waits for the next decrement tick of that counter. On that tick it copies the counter value, before the decrement, into a 16-bit holding register. Both bytes therefore come from a single counter value, taken between decrements. While the snapshot is held, reads of that timer's addresses are steered to it. A read of the low byte releases the snapshot and clears the request. After that, reads return the preset again.

The counter itself, its modes and its interrupts live elsewhere. This block only receives the count value and the decrement strobe.

Top module: `timer_snap_latch`

## Requirements
- R1: While a timer's read bit is clear, the byte at address BASE_ADDR+2*i (0x0F for timer 0, 0x11 for timer 1) returns bits 7:0 of that timer's preset. The byte at BASE_ADDR+2*i+1 (0x10, 0x12) returns bits 15:8.
- R2: A pulse on `rd_req_set[i]` while the read bit is clear makes `rd_bit[i]` read 1 from the next cycle on.
- R3: The snapshot is taken on the first cycle after the request cycle in which `cnt_tick[i]` is high. It holds the `count_in` value presented in that cycle. A tick in the request cycle itself does not capture. Successive snapshots of a free-running down-counter never increase, unless the counter has been reloaded in between.
- R4: While the request is armed but nothing has been captured, reads of that timer's addresses still return the preset.
- R5: Once captured, both byte addresses return the snapshot. Later ticks do not change it.
- R6: A host read (`host_rd_en`) of the low-byte address while the snapshot is held clears `rd_bit[i]` on the next cycle, and reads return the preset again. A read of the high-byte address does not clear it.
- R7: A low-byte read while the request is armed but not yet captured leaves the read bit set.
- R8: A further request while the read bit is set has no effect. The snapshot and the read bit are unchanged.
- R9: An address outside the timer window returns 0x00 and changes no state.
- R10: The timers are independent. A request, tick or read for one timer does not change another timer's read bit or data.
- R11: During reset and right after it, every read bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_tick | input | NUM_TIMERS | Per-timer decrement strobe; the counter changes at the edge where this is high |
| count_in | input | NUM_TIMERS*CNT_W | Live counter values, timer i in slice i |
| preset_in | input | NUM_TIMERS*CNT_W | Preset (reload) values, timer i in slice i |
| rd_req_set | input | NUM_TIMERS | One-cycle pulse: host wrote 1 to timer i's read bit |
| host_rd_en | input | 1 | Host read strobe for the current address |
| host_addr | input | ADDR_W | Host byte address |
| host_rd_data | output | 8 | Read data for `host_addr` (combinational) |
| rd_bit | output | NUM_TIMERS | Read-bit state, visible to the host through the control register |

## Verification
The assertions assume two things about `count_in`. It changes only at edges where the matching `cnt_tick` bit is high, and it is stable when the snapshot is taken. The bench meets this by driving counters that update only on their own tick. The assertions also assume that `host_addr` and `host_rd_en` are steady for the whole cycle. The bench changes every input a fixed time after the falling edge, so inputs are steady when each rising edge samples them.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
    typedef enum logic [1:0] {
        SN_IDLE  = 2'd0,
        SN_ARMED = 2'd1,
        SN_HELD  = 2'd2
    } snap_st_e;
endpackage

// File: rtl/tsl_chan.sv
// One timer's snapshot channel: request arming, tick-aligned capture, release.
module tsl_chan
    import tsl_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             req_set,
    input  logic             lo_rd,
    input  logic [CNT_W-1:0] count_in,
    output logic             rd_bit,
    output logic             held,
    output logic [CNT_W-1:0] snap
);
    typedef struct packed {
        snap_st_e         st;
        logic [CNT_W-1:0] snap;
    } chan_s;

    chan_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            SN_IDLE: begin
                if (req_set) nxt_d.st = SN_ARMED;
            end
            SN_ARMED: begin
                // capture on the decrement edge: the pre-decrement value is stable
                if (tick) begin
                    nxt_d.snap = count_in;
                    nxt_d.st   = SN_HELD;
                end
            end
            SN_HELD: begin
                if (lo_rd) nxt_d.st = SN_IDLE;
            end
            default: nxt_d.st = SN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: SN_IDLE, snap: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rd_bit = (cur_q.st != SN_IDLE);
    assign held   = (cur_q.st == SN_HELD);
    assign snap   = cur_q.snap;
endmodule

// File: rtl/tsl_rdmux.sv
// Address decode and byte steering between preset and snapshot.
module tsl_rdmux #(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 5,
    parameter int BASE_ADDR  = 15
) (
    input  logic                        host_rd_en,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic [NUM_TIMERS*CNT_W-1:0] preset_flat,
    input  logic [NUM_TIMERS*CNT_W-1:0] snap_flat,
    input  logic [NUM_TIMERS-1:0]       held,
    output logic [7:0]                  rd_data,
    output logic [NUM_TIMERS-1:0]       lo_hit
);
    localparam int BYTES = CNT_W / 8;

    always_comb begin
        rd_data = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (host_addr == ADDR_W'(BASE_ADDR + t * BYTES + b)) begin
                    rd_data = held[t] ? snap_flat[t*CNT_W + b*8 +: 8]
                                      : preset_flat[t*CNT_W + b*8 +: 8];
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_lo
        assign lo_hit[g] = host_rd_en && (host_addr == ADDR_W'(BASE_ADDR + g * BYTES));
    end
endmodule

// File: rtl/timer_snap_latch.sv
module timer_snap_latch #(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 5,
    parameter int BASE_ADDR  = 15
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TIMERS-1:0]       cnt_tick,
    input  logic [NUM_TIMERS*CNT_W-1:0] count_in,
    input  logic [NUM_TIMERS*CNT_W-1:0] preset_in,
    input  logic [NUM_TIMERS-1:0]       rd_req_set,
    input  logic                        host_rd_en,
    input  logic [ADDR_W-1:0]           host_addr,
    output logic [7:0]                  host_rd_data,
    output logic [NUM_TIMERS-1:0]       rd_bit
);
    logic [NUM_TIMERS-1:0]       held_w;
    logic [NUM_TIMERS-1:0]       lo_hit_w;
    logic [NUM_TIMERS*CNT_W-1:0] snap_w;

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chan
        tsl_chan #(.CNT_W(CNT_W)) chan_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (cnt_tick[g]),
            .req_set  (rd_req_set[g]),
            .lo_rd    (lo_hit_w[g]),
            .count_in (count_in[g*CNT_W +: CNT_W]),
            .rd_bit   (rd_bit[g]),
            .held     (held_w[g]),
            .snap     (snap_w[g*CNT_W +: CNT_W])
        );
    end

    tsl_rdmux #(
        .NUM_TIMERS (NUM_TIMERS),
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR)
    ) mux_i (
        .host_rd_en  (host_rd_en),
        .host_addr   (host_addr),
        .preset_flat (preset_in),
        .snap_flat   (snap_w),
        .held        (held_w),
        .rd_data     (host_rd_data),
        .lo_hit      (lo_hit_w)
    );
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker #(
    parameter int NUM_TIMERS = 2,
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 5,
    parameter int BASE_ADDR  = 15
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_TIMERS-1:0]       cnt_tick,
    input logic [NUM_TIMERS*CNT_W-1:0] count_in,
    input logic [NUM_TIMERS*CNT_W-1:0] preset_in,
    input logic [NUM_TIMERS-1:0]       rd_req_set,
    input logic [ADDR_W-1:0]           host_addr,
    input logic [7:0]                  host_rd_data,
    input logic [NUM_TIMERS-1:0]       rd_bit,
    input logic [NUM_TIMERS-1:0]       held,
    input logic [NUM_TIMERS-1:0]       lo_hit,
    input logic [NUM_TIMERS*CNT_W-1:0] snap_flat
);
    localparam int BYTES = CNT_W / 8;

    p_reset_r11: assert property (@(posedge clk) !rst_n |-> rd_bit == '0);

    for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_chk
        p_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req_set[g] && !rd_bit[g]) |=> rd_bit[g]);

        p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_bit[g] && !held[g] && cnt_tick[g]) |=>
                (held[g] && snap_flat[g*CNT_W +: CNT_W] == $past(count_in[g*CNT_W +: CNT_W])));

        p_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_bit[g] && !held[g] && !cnt_tick[g]) |=> (rd_bit[g] && !held[g]));

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (held[g] && !lo_hit[g]) |=> (held[g] && $stable(snap_flat[g*CNT_W +: CNT_W])));

        p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (held[g] && lo_hit[g]) |=> !rd_bit[g]);

        p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!held[g] && host_addr == ADDR_W'(BASE_ADDR + g * BYTES)) |->
                host_rd_data == preset_in[g*CNT_W +: 8]);
    end
endmodule

bind timer_snap_latch tsl_checker #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_tick     (cnt_tick),
    .count_in     (count_in),
    .preset_in    (preset_in),
    .rd_req_set   (rd_req_set),
    .host_addr    (host_addr),
    .host_rd_data (host_rd_data),
    .rd_bit       (rd_bit),
    .held         (held_w),
    .lo_hit       (lo_hit_w),
    .snap_flat    (snap_w)
);

// File: tb/timer_snap_latch_tb_top.sv
`timescale 1ns/1ps
module timer_snap_latch_tb_top;
    localparam int N = 2;
    localparam int W = 16;
    localparam int BASE = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] tick;
    logic [N-1:0] man_tick = '0;
    logic [N-1:0] rnd_tick = '0;
    logic         auto_tick = 1'b0;
    logic [W-1:0] cnt [N];
    logic [W-1:0] pre [N];
    logic [N-1:0] req = '0;
    logic         rd_en = 1'b0;
    logic [4:0]   addr = '0;
    logic [7:0]   rdata;
    logic [N-1:0] rbit;
    logic         cmp_on = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int mst [N];
    logic [W-1:0] msnap [N];
    int reloads [N];

    always #10 clk = ~clk;

    assign tick = auto_tick ? rnd_tick : man_tick;

    timer_snap_latch dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_tick     (tick),
        .count_in     ({cnt[1], cnt[0]}),
        .preset_in    ({pre[1], pre[0]}),
        .rd_req_set   (req),
        .host_rd_en   (rd_en),
        .host_addr    (addr),
        .host_rd_data (rdata),
        .rd_bit       (rbit)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #2;
    endtask

    always @(negedge clk) rnd_tick <= N'($urandom_range(0, 3));

    // free-running counters and behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt[0] <= 16'h0900;
            cnt[1] <= 16'h0C40;
            for (int i = 0; i < N; i++) begin
                mst[i] = 0;
                msnap[i] = '0;
                reloads[i] = 0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (mst[i] == 0) begin
                    if (req[i]) mst[i] = 1;
                end else if (mst[i] == 1) begin
                    if (tick[i]) begin
                        msnap[i] = cnt[i];
                        mst[i] = 2;
                    end
                end else begin
                    if (rd_en && addr == 5'(BASE + 2 * i)) mst[i] = 0;
                end
                if (tick[i]) begin
                    if (cnt[i] == 0) begin
                        cnt[i] <= 16'h0A00;
                        reloads[i] = reloads[i] + 1;
                    end else begin
                        cnt[i] <= cnt[i] - 1'b1;
                    end
                end
            end
        end
    end

    function automatic int exp_data(input logic [4:0] a);
        int off;
        logic [W-1:0] src;
        off = int'(a) - BASE;
        if (off < 0 || off >= 2 * N) return 0;
        src = (mst[off/2] == 2) ? msnap[off/2] : pre[off/2];
        return (off % 2) ? int'(src[15:8]) : int'(src[7:0]);
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            for (int i = 0; i < N; i++) begin
                chk(rbit[i] == (mst[i] != 0), (mst[i] == 1) ? "R2 read bit" :
                    (mst[i] == 2) ? "R3 read bit" : "R6 read bit",
                    int'(rbit[i]), int'(mst[i] != 0));
            end
            if (int'(addr) < BASE || int'(addr) >= BASE + 2 * N)
                chk(int'(rdata) == exp_data(addr), "R9 outside data", int'(rdata), exp_data(addr));
            else if (mst[(int'(addr) - BASE) / 2] == 2)
                chk(int'(rdata) == exp_data(addr), "R5 snapshot data", int'(rdata), exp_data(addr));
            else
                chk(int'(rdata) == exp_data(addr), "R1/R4 preset data", int'(rdata), exp_data(addr));
        end
    end

    task automatic grab(input int i, output logic [W-1:0] v, output int rl);
        req[i] = 1'b1;
        cyc();
        req[i] = 1'b0;
        for (int k = 0; k < 200 && mst[i] != 2; k++) cyc();
        rl = reloads[i];
        addr = 5'(BASE + 2 * i + 1);
        #1 v[15:8] = rdata;
        cyc();
        addr = 5'(BASE + 2 * i);
        rd_en = 1'b1;
        #1 v[7:0] = rdata;
        cyc();
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        #3_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] cap0, cap1, v;
        logic [W-1:0] last [N];
        int last_rl [N];
        int rl;
        pre[0] = 16'hA55A;
        pre[1] = 16'h3CC3;
        repeat (3) cyc();
        chk(rbit == '0, "R11 in reset", int'(rbit), 0);
        rst_n = 1'b1;
        cyc();
        chk(rbit == '0, "R11 after reset", int'(rbit), 0);
        cmp_on = 1'b1;

        // R1: preset bytes at each address while idle
        for (int a = BASE; a < BASE + 2 * N; a++) begin
            addr = 5'(a);
            #1 chk(int'(rdata) == ((a % 2) ? int'(pre[(a-BASE)/2][7:0]) : int'(pre[(a-BASE)/2][15:8])),
                   "R1 preset byte", int'(rdata), 0);
        end
        // R9: outside window
        addr = 5'h05; rd_en = 1'b1;
        #1 chk(rdata == 8'h00, "R9 low outside", int'(rdata), 0);
        cyc();
        addr = 5'h13;
        #1 chk(rdata == 8'h00, "R9 high outside", int'(rdata), 0);
        cyc();
        rd_en = 1'b0;
        chk(rbit == '0, "R9 no state change", int'(rbit), 0);

        // R2 / R10: arm timer 0 only
        req[0] = 1'b1;
        cyc();
        req[0] = 1'b0;
        chk(rbit == 2'b01, "R2 R10 arm timer0", int'(rbit), 1);
        // R7 / R4: low read while armed
        addr = 5'(BASE); rd_en = 1'b1;
        #1 chk(rdata == pre[0][7:0], "R4 armed returns preset", int'(rdata), int'(pre[0][7:0]));
        cyc();
        rd_en = 1'b0;
        chk(rbit[0] == 1'b1, "R7 armed low read ignored", int'(rbit[0]), 1);
        // R3: capture on tick
        cap0 = cnt[0];
        man_tick = 2'b01;
        cyc();
        man_tick = 2'b00;
        addr = 5'(BASE + 1);
        #1 chk(rdata == cap0[15:8], "R3 captured high", int'(rdata), int'(cap0[15:8]));
        addr = 5'(BASE);
        #1 chk(rdata == cap0[7:0], "R3 captured low", int'(rdata), int'(cap0[7:0]));
        // R5: more ticks do not disturb
        man_tick = 2'b01;
        repeat (3) cyc();
        man_tick = 2'b00;
        addr = 5'(BASE + 1);
        #1 chk(rdata == cap0[15:8], "R5 snapshot stable", int'(rdata), int'(cap0[15:8]));
        // R8: repeat request ignored
        req[0] = 1'b1;
        man_tick = 2'b01;
        cyc();
        req[0] = 1'b0;
        man_tick = 2'b00;
        cyc();
        addr = 5'(BASE);
        #1 chk(rdata == cap0[7:0], "R8 re-request ignored", int'(rdata), int'(cap0[7:0]));
        chk(rbit[0] == 1'b1, "R8 bit kept", int'(rbit[0]), 1);
        // R3 / R10: tick in request cycle does not capture on timer 1
        req[1] = 1'b1;
        man_tick = 2'b10;
        cyc();
        req[1] = 1'b0;
        man_tick = 2'b00;
        addr = 5'(BASE + 2);
        #1 chk(rdata == pre[1][7:0], "R3 no capture in request cycle", int'(rdata), int'(pre[1][7:0]));
        chk(rbit == 2'b11, "R10 both set", int'(rbit), 3);
        cap1 = cnt[1];
        man_tick = 2'b10;
        cyc();
        man_tick = 2'b00;
        addr = 5'(BASE + 3);
        #1 chk(rdata == cap1[15:8], "R10 timer1 snapshot", int'(rdata), int'(cap1[15:8]));
        addr = 5'(BASE + 1);
        #1 chk(rdata == cap0[15:8], "R10 timer0 untouched", int'(rdata), int'(cap0[15:8]));
        // R6: high read keeps, low read releases
        rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk(rbit[0] == 1'b1, "R6 high read keeps bit", int'(rbit[0]), 1);
        addr = 5'(BASE); rd_en = 1'b1;
        #1 chk(rdata == cap0[7:0], "R6 low read data", int'(rdata), int'(cap0[7:0]));
        cyc();
        rd_en = 1'b0;
        chk(rbit == 2'b10, "R6 R10 release timer0 only", int'(rbit), 2);
        #1 chk(rdata == pre[0][7:0], "R6 preset after release", int'(rdata), int'(pre[0][7:0]));
        addr = 5'(BASE + 2); rd_en = 1'b1;
        cyc();
        rd_en = 1'b0;
        chk(rbit == 2'b00, "R6 release timer1", int'(rbit), 0);

        // R3: monotonic snapshots of free-running counters
        auto_tick = 1'b1;
        for (int i = 0; i < N; i++) begin
            last[i] = '1;
            last_rl[i] = -1;
        end
        for (int k = 0; k < 160; k++) begin
            grab(k % N, v, rl);
            if (rl == last_rl[k % N])
                chk(v <= last[k % N], "R3 snapshot not increasing", int'(v), int'(last[k % N]));
            last[k % N] = v;
            last_rl[k % N] = rl;
        end

        // random traffic, compared every cycle
        for (int k = 0; k < 3000; k++) begin
            req = N'($urandom_range(0, 7) == 0 ? $urandom_range(1, 3) : 0);
            addr = 5'($urandom_range(13, 20));
            rd_en = ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 49) == 0) pre[$urandom_range(0, 1)] = 16'($urandom);
            cyc();
        end
        req = '0;
        rd_en = 1'b0;
        cyc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule